// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block runs single read or write accesses on a strobe-based asynchronous bus of the classic 68k kind, on behalf of an on-chip requester. A request carries an address, a direction and, for writes, a data word. The sequencer drives the address and direction lines, asserts an address strobe, a data strobe and a chip select, and turns on the write-data driver when a write needs it. It then waits for the device's active-low acknowledge, captures the read data and ends the access by releasing the strobes. The result goes back to the requester as a response word with an error flag.

The block's clock runs at twice the bus state rate, so every clock cycle is one half-state. A cycle with no wait runs S0 to S5. The acknowledge is asynchronous and passes through a two-stage synchronizer. It is checked in S3 and again in the second half of each inserted wait pair. Chip select follows the address strobe on reads and the data strobe on writes, so the write data is already stable when select falls. A wait limit given in bus clocks bounds the wait pairs. When the limit runs out the access is cut short and an error is reported.

Both data interfaces use valid/ready. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` stays low while an access runs, while a response waits, and while the synchronized acknowledge is still low. A response stays on `rsp_valid` with its fields held until the requester raises `rsp_ready`. The requester can therefore stall the block for as long as it needs without losing a result.

Top module: `async_bus_seq`

## Requirements
- R1: After reset, `bus_as_n`, `bus_ds_n` and `bus_cs_n` are high, `bus_data_oe` is low, `bus_read` is high, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken on a clock with `req_valid` and `req_ready` both high. From then on `req_ready` stays low until the response has been taken. `rsp_valid` and `req_ready` are never high together.
- R3: The first cycle after a request is taken is S0, where address and direction are driven and all strobes are high. `bus_as_n` falls in the next cycle (S1). `bus_ds_n` falls two cycles after that (S3). The data strobe is low only while the address strobe is low. Both strobes rise together in S5.
- R4: On a read (`bus_read`=1), `bus_cs_n` falls and rises with `bus_as_n`.
- R5: On a write (`bus_read`=0), `bus_cs_n` falls and rises with `bus_ds_n`. `bus_data_oe` is high from S2 up to and including S5: it is already on when select falls and stays on for the half-state after select rises. `bus_wdata` carries the request data while the driver is on.
- R6: During a read access `bus_data_oe` is never high.
- R7: `bus_ack_n` goes through a two-flop synchronizer. It is checked in S3 and in the last half of each wait pair. Each check that finds no acknowledge adds one wait pair of two cycles, and both strobes stay low through it. With no waits, the address strobe is low for 4 cycles and the data strobe for 2.
- R8: On a read, `bus_rdata` is captured at the end of S4 and returned on `rsp_rdata`. On a write, `rsp_rdata` is 0.
- R9: In S5, after the strobes rise, `bus_addr` and `bus_read` still hold the values of the access.
- R10: Suppose a check finds no acknowledge after `cfg_wait_limit` wait pairs have already been inserted. The access then skips S4 and goes straight to S5. The response has `rsp_err`=1 and `rsp_rdata`=0. A limit of 0 allows no wait pair.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` stay unchanged.
- R12: No new request is taken while the synchronized acknowledge is still low, that is, until the device has released `bus_ack_n` and the release has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus state rate (one half-state per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_limit | input | WAIT_W | Largest number of wait pairs allowed before the access is aborted |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DW | Read data (0 for writes and aborted accesses) |
| rsp_err | output | 1 | Access aborted by the wait limit |
| bus_addr | output | AW | Bus address |
| bus_read | output | 1 | Direction: 1 = read, 0 = write; 1 when idle |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_data_oe | output | 1 | Enable for the external write-data driver |
| bus_wdata | output | DW | Write data toward the bus |
| bus_rdata | input | DW | Read data from the bus |
| bus_ack_n | input | 1 | Asynchronous data acknowledge from the device, active low |

## Verification
The bench builds the block with a 4-bit wait limit, a 24-bit address and a 16-bit data word. With a 4-bit limit, the largest limit of 15 wait pairs can be run in a directed case, so a full timer count without overflow is exercised along with the zero limit. The bench's device model acknowledges after a chosen number of half-states, and the delays cover both sides of each drawn limit. This drives accesses through clean completion, exact-limit completion and abort. A device that holds its acknowledge after select rises brings the stale-acknowledge guard into play.

// File: rtl/asb_pkg.sv
package asb_pkg;

  // One state per half bus clock; WAIT_A/WAIT_B form an inserted wait pair.
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_S0     = 4'd1,
    ST_S1     = 4'd2,
    ST_S2     = 4'd3,
    ST_S3     = 4'd4,
    ST_WAIT_A = 4'd5,
    ST_WAIT_B = 4'd6,
    ST_S4     = 4'd7,
    ST_S5     = 4'd8
  } asb_state_e;

endpackage

// File: rtl/asb_sync.sv
module asb_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/asb_wait_timer.sv
module asb_wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [WAIT_W-1:0] limit,
  output logic              expired
);

  logic [WAIT_W-1:0] pairs_q;

  // step is only raised while pairs_q differs from limit, so no wrap occurs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pairs_q <= '0;
    else if (clear) pairs_q <= '0;
    else if (step)  pairs_q <= pairs_q + 1'b1;
  end

  assign expired = (pairs_q == limit);

endmodule

// File: rtl/asb_seq_fsm.sv
module asb_seq_fsm
  import asb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ack_seen,
  input  logic       expired,
  output asb_state_e state,
  output logic       step,
  output logic       abort
);

  asb_state_e state_q, state_d;
  logic       abort_q;
  logic       check;

  assign check = (state_q == ST_S3) || (state_q == ST_WAIT_B);
  assign step  = check && !ack_seen && !expired;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_S0;
      ST_S0:     state_d = ST_S1;
      ST_S1:     state_d = ST_S2;
      ST_S2:     state_d = ST_S3;
      ST_S3, ST_WAIT_B: begin
        if (ack_seen)     state_d = ST_S4;
        else if (expired) state_d = ST_S5;
        else              state_d = ST_WAIT_A;
      end
      ST_WAIT_A: state_d = ST_WAIT_B;
      ST_S4:     state_d = ST_S5;
      ST_S5:     state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start)
        abort_q <= 1'b0;
      else if (check && !ack_seen && expired)
        abort_q <= 1'b1;
    end
  end

  assign state = state_q;
  assign abort = abort_q;

endmodule

// File: rtl/async_bus_seq.sv
module async_bus_seq
  import asb_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int WAIT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_read,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_cs_n,
  output logic              bus_data_oe,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack_n
);

  localparam logic [DW-1:0] DATA_ZERO = '0;

  asb_state_e    state;
  logic          ack_n_sync, ack_seen;
  logic          start, step, expired, abort;
  logic          in_cycle, as_win, ds_win, oe_win;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          write_q, rsp_valid_q;

  asb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_ack_n),
    .q     (ack_n_sync)
  );
  assign ack_seen = !ack_n_sync;

  asb_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .step    (step),
    .limit   (cfg_wait_limit),
    .expired (expired)
  );

  asb_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ack_seen (ack_seen),
    .expired  (expired),
    .state    (state),
    .step     (step),
    .abort    (abort)
  );

  // Request side: one access in flight, response must drain, device must let go
  assign req_ready = (state == ST_IDLE) && !rsp_valid_q && !ack_seen;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  // Strobe windows in half-states
  always_comb begin
    in_cycle = (state != ST_IDLE);
    as_win   = 1'b0;
    ds_win   = 1'b0;
    oe_win   = 1'b0;
    unique case (state)
      ST_S1:                      as_win = 1'b1;
      ST_S2:           begin as_win = 1'b1; oe_win = 1'b1; end
      ST_S3, ST_WAIT_A, ST_WAIT_B, ST_S4:
                       begin as_win = 1'b1; ds_win = 1'b1; oe_win = 1'b1; end
      ST_S5:                      oe_win = 1'b1;
      default: ;
    endcase
  end

  assign bus_addr    = addr_q;
  assign bus_read    = !(in_cycle && write_q);
  assign bus_as_n    = !as_win;
  assign bus_ds_n    = !ds_win;
  assign bus_cs_n    = write_q ? !ds_win : !as_win;
  assign bus_data_oe = write_q && oe_win;
  assign bus_wdata   = wdata_q;

  // Read capture at the end of S4 and response hand-off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q     <= DATA_ZERO;
      rsp_valid_q <= 1'b0;
    end else begin
      if (start)
        rdata_q <= DATA_ZERO;
      else if (state == ST_S4 && !write_q)
        rdata_q <= bus_rdata;

      if (state == ST_S5)
        rsp_valid_q <= 1'b1;
      else if (rsp_valid_q && rsp_ready)
        rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;
  assign rsp_err   = abort;

endmodule

// File: rtl/asb_seq_chk.sv
module asb_seq_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic [AW-1:0] bus_addr,
  input logic          bus_read,
  input logic          bus_as_n,
  input logic          bus_ds_n,
  input logic          bus_cs_n,
  input logic          bus_data_oe,
  input logic          ack_seen
);

  // R2
  rsp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3
  ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> !bus_as_n);

  // R4
  read_cs_follows_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |-> (bus_cs_n == bus_as_n));

  // R5
  write_cs_follows_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_read |-> (bus_cs_n == bus_ds_n));

  // R5
  write_oe_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_cs_n) && !bus_read) |-> bus_data_oe);

  // R5
  write_oe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_cs_n) && !bus_read) |-> bus_data_oe);

  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |-> !bus_data_oe);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> ($stable(bus_addr) && $stable(bus_read)));

  // R10
  abort_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R12
  stale_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |-> !req_ready);

endmodule

bind async_bus_seq asb_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .bus_addr    (bus_addr),
  .bus_read    (bus_read),
  .bus_as_n    (bus_as_n),
  .bus_ds_n    (bus_ds_n),
  .bus_cs_n    (bus_cs_n),
  .bus_data_oe (bus_data_oe),
  .ack_seen    (ack_seen)
);

// File: tb/async_bus_seq_test.sv
module async_bus_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WAIT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WAIT_W-1:0] cfg_wait_limit = '0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              req_ready, rsp_valid, rsp_err;
  logic              rsp_ready = 1'b0;
  logic [DW-1:0]     rsp_rdata;
  logic [AW-1:0]     bus_addr;
  logic              bus_read, bus_as_n, bus_ds_n, bus_cs_n, bus_data_oe;
  logic [DW-1:0]     bus_wdata;
  logic [DW-1:0]     bus_rdata = '0;
  logic              bus_ack_n = 1'b1;

  int checks = 0;
  int errors = 0;

  async_bus_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wait_limit(cfg_wait_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_cs_n(bus_cs_n), .bus_data_oe(bus_data_oe), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Device model: acknowledge dev_delay negedges after select is seen low
  int          dev_delay = 0, dev_linger = 0, cs_seen = 0, linger_cnt = 0;
  logic [DW-1:0] dev_data = '0;

  always @(negedge clk) begin
    if (!bus_cs_n) begin
      if (dev_delay >= 0 && cs_seen == dev_delay) begin
        bus_ack_n = 1'b0;
        bus_rdata = dev_data;
      end
      cs_seen++;
    end else begin
      cs_seen = 0;
      if (!bus_ack_n) begin
        if (linger_cnt >= dev_linger) begin
          bus_ack_n = 1'b1;
          linger_cnt = 0;
        end else linger_cnt++;
      end
    end
  end

  // Monitor: starts in the S0 cycle after a handshake
  logic          hs_q = 1'b0;
  bit            mon_en = 0, prev_as = 0;
  int            m_idx, as_cnt, ds_cnt, cs_cnt, oe_cnt, first_as, first_ds, first_cs, bad_addr, bad_wd;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_wdata;
  bit            exp_write;

  always @(posedge clk) hs_q <= req_valid && req_ready;

  always @(negedge clk) begin
    if (hs_q) begin
      mon_en = 1; m_idx = 0; as_cnt = 0; ds_cnt = 0; cs_cnt = 0; oe_cnt = 0;
      first_as = -1; first_ds = -1; first_cs = -1; bad_addr = 0; bad_wd = 0; prev_as = 0;
      if (!bus_as_n || !bus_ds_n || !bus_cs_n || bus_data_oe) bad_addr++;
    end
    if (mon_en) begin
      if (!bus_as_n) begin as_cnt++; if (first_as < 0) first_as = m_idx; end
      if (!bus_ds_n) begin ds_cnt++; if (first_ds < 0) first_ds = m_idx; end
      if (!bus_cs_n) begin cs_cnt++; if (first_cs < 0) first_cs = m_idx; end
      if (bus_data_oe) oe_cnt++;
      if (hs_q || !bus_as_n || bus_data_oe || prev_as)
        if (bus_addr !== exp_addr || bus_read !== !exp_write) bad_addr++;
      if (bus_data_oe && bus_wdata !== exp_wdata) bad_wd++;
      prev_as = !bus_as_n;
      m_idx++;
    end
  end

  function automatic int exp_pairs(input bit wr, input int d, input int lim, output bit ab);
    int v, w;
    if (d < 0) begin ab = 1; return lim; end
    v = (wr ? 5 : 3) + d;
    w = (v <= 3) ? 0 : (v - 2) / 2;
    if (w > lim) begin ab = 1; return lim; end
    ab = 0;
    return w;
  endfunction

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int d, input int lim, input int linger, input int hold);
    bit ab;
    int m;
    logic [DW-1:0] r0;
    logic e0;
    m = exp_pairs(wr, d, lim, ab);
    dev_delay = d; dev_linger = linger; dev_data = DW'($urandom);
    cfg_wait_limit = WAIT_W'(lim);
    exp_addr = a; exp_wdata = wd; exp_write = wr;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "ready low during access", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    mon_en = 0;
    check("R3", "address strobe first half-state", first_as, 1);
    check("R3", "data strobe first half-state", first_ds, 3);
    check("R7", "address strobe length", as_cnt, ab ? 3 + 2*m : 4 + 2*m);
    check("R7", "data strobe length", ds_cnt, ab ? 1 + 2*m : 2 + 2*m);
    if (wr) begin
      check("R5", "select with data strobe, length", cs_cnt, ds_cnt);
      check("R5", "select first half-state", first_cs, 3);
      check("R5", "driver length", oe_cnt, ab ? 3 + 2*m : 4 + 2*m);
      check("R5", "write data mismatches", bad_wd, 0);
    end else begin
      check("R4", "select with address strobe, length", cs_cnt, as_cnt);
      check("R4", "select first half-state", first_cs, 1);
      check("R6", "driver on during read", oe_cnt, 0);
    end
    check("R9", "address/direction mismatches incl. S5", bad_addr, 0);
    check("R10", "error flag", rsp_err, ab);
    check("R8", "read data", rsp_rdata, (wr || ab) ? 0 : dev_data);
    r0 = rsp_rdata; e0 = rsp_err;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11", "response held", {rsp_valid, rsp_rdata, rsp_err}, {1'b1, r0, e0});
      check("R2", "ready low while response pending", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R11", "response taken", rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b2c3d4e));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset strobes", {bus_as_n, bus_ds_n, bus_cs_n}, 3'b111);
    check("R1", "reset driver", bus_data_oe, 0);
    check("R1", "reset direction", bus_read, 1);
    check("R1", "reset response", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", req_ready, 1);

    // Directed corners
    run_txn(0, 24'h123456, 16'h0000, 0, 0, 0, 0);   // read, no waits, limit 0
    run_txn(0, 24'h000001, 16'h0000, 1, 0, 0, 0);   // read needing one pair, limit 0: abort
    run_txn(1, 24'hABCDEF, 16'hA55A, 0, 1, 0, 0);   // write, exactly at limit
    run_txn(1, 24'hFFFFFF, 16'h0F0F, -1, 15, 0, 0); // write, no ack, full limit
    run_txn(0, 24'h00F00F, 16'h0000, 6, 4, 0, 5);   // read with back-pressure

    // R12 stale acknowledge held after select rises
    run_txn(0, 24'h777777, 16'h0000, 2, 5, 8, 0);
    check("R12", "ready blocked by held ack", req_ready, 0);
    repeat (14) @(negedge clk);
    check("R12", "ready after ack release", req_ready, 1);

    // Constrained random
    for (int n = 0; n < 60; n++) begin
      bit wr;
      int d;
      wr = $urandom_range(0, 1) == 1;
      d  = ($urandom_range(0, 9) == 0) ? -1 : int'($urandom_range(0, 12));
      run_txn(wr, AW'($urandom), DW'($urandom), d, $urandom_range(0, 6),
              $urandom_range(0, 3), $urandom_range(0, 3));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule